// File: doc/BRIEF.md
# BCD Alarm Comparator with Wildcard Fields

This block decides, on every time update, whether the current calendar time hits a programmed alarm. It keeps five alarm bytes: second, minute and hour, plus optional day-of-month and month bytes. Together they let an alarm be set anywhere up to a year ahead. The time itself arrives from outside as packed BCD bytes, alongside a one-cycle update strobe. Keeping and advancing the time is the job of other logic.

Each alarm byte can be set to a "don't care" code, so that its field matches every value. This gives alarms that repeat every second, every minute, every hour or every day. The day byte compares only its low six bits. A day or month byte of zero counts as unset.

On an update strobe, the comparator checks all five fields against the alarm bytes. When every field matches, it raises a one-cycle event on the next clock, and the interrupt flag logic takes that event in. Software loads the alarm bytes through a simple write port with a field select. A build parameter removes the day and month bytes entirely, and those fields then always match.

Top module: `bcd_alarm_match`

## Requirements
- R1: After reset, `alarm_pulse` is low, the second, minute and hour alarm bytes are 0x00, and the day and month bytes are 0x00 (unset). The alarm therefore fires at 00:00:00 on any date.
- R2: `alarm_pulse` is high exactly in the cycle after a cycle with `tick` high in which every field matches, and it is low in every other cycle.
- R3: A cycle with `wr_en` high loads `wr_data` into the byte picked by `wr_sel`: 0 second, 1 minute, 2 hour, 3 day of month, 4 month. Codes 5 to 7 change nothing. A new byte is first used by a `tick` in a later cycle; a `tick` in the same cycle as the write still uses the old byte.
- R4: A second, minute or hour alarm byte whose bits 7 and 6 are both 1 (for example 0xFF or 0xC5) matches any current value of that field.
- R5: Any other second, minute or hour alarm byte matches only when it equals the current byte in all 8 bits. An out-of-range byte such as 0x80 therefore never matches a valid time.
- R6: The day-of-month compare uses alarm bits 5:0 against current bits 5:0. Alarm bits 7:6 play no part, so 0xD5 behaves as 0x15.
- R7: A day-of-month alarm whose bits 5:0 are all 0 or all 1 (for example 0x00, 0x40 or 0xFF) matches every day.
- R8: A month alarm byte of 0x00, or one whose bits 7:6 are both 1, matches every month. Any other month byte needs exact 8-bit equality.
- R9: With `HAS_DATE` = 0, the day and month bytes do not exist: writes with codes 3 and 4 have no effect, and the day and month fields always match.
- R10: Strobes in consecutive cycles are judged independently, and each matching strobe gives its own pulse, so back-to-back pulses are possible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time update strobe, one cycle per new time value |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD, 24-hour |
| cur_mday | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, BCD |
| wr_en | input | 1 | Alarm byte write enable |
| wr_sel | input | 3 | Alarm byte select (0 sec, 1 min, 2 hour, 3 day, 4 month) |
| wr_data | input | 8 | Alarm byte write data |
| alarm_pulse | output | 1 | One-cycle alarm event |

## Verification
The only observable state is the set of alarm bytes, and any corruption of them shows up at `alarm_pulse`. A wrong alarm byte or a broken wildcard decode gives a missing or extra pulse in the cycle after the next strobe that carries a telling time. The bench therefore moves the time across each field's match, miss and wildcard codes, and compares the pulse against a reference model on every clock. Writes with unused select codes, and writes that land in the same cycle as a strobe, are checked the same way: by the pulse on the strobes that follow.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;

   localparam int BCD_BYTE_W = 8;
   localparam int ALM_FIELDS = 5;
   localparam int ALM_SEL_W  = 3;

   typedef enum logic [ALM_SEL_W-1:0] {
      SEL_SEC  = 3'd0,
      SEL_MIN  = 3'd1,
      SEL_HOUR = 3'd2,
      SEL_MDAY = 3'd3,
      SEL_MON  = 3'd4
   } alm_sel_e;

   typedef enum int {
      CMP_CLOCK = 0,
      CMP_MDAY  = 1,
      CMP_MONTH = 2
   } cmp_kind_e;

   function automatic cmp_kind_e kind_of_field(input int idx);
      if (idx == int'(SEL_MDAY)) return CMP_MDAY;
      if (idx == int'(SEL_MON))  return CMP_MONTH;
      return CMP_CLOCK;
   endfunction

endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
   import bcd_alarm_pkg::*;
#(
   parameter int W        = BCD_BYTE_W,
   parameter int NF       = ALM_FIELDS,
   parameter int SEL_W    = ALM_SEL_W,
   parameter bit HAS_DATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SEL_W-1:0]     wr_sel,
   input  logic [W-1:0]         wr_data,
   output logic [NF-1:0][W-1:0] alm
);

   localparam int CLOCK_FIELDS = int'(SEL_MDAY);

   generate
      if (NF > (1 << SEL_W)) begin : g_bad_sel
         $error("alarm_regfile: select too narrow for field count");
      end
   endgenerate

   for (genvar i = 0; i < NF; i++) begin : g_field
      if (i < CLOCK_FIELDS || HAS_DATE) begin : g_reg
         logic [W-1:0] alm_q;
         logic         hit_sel;

         assign hit_sel = wr_en && (wr_sel == SEL_W'(i));

         always_ff @(posedge clk) begin
            if (!rst_n)       alm_q <= '0;
            else if (hit_sel) alm_q <= wr_data;
         end

         assign alm[i] = alm_q;

         // R3: a write lands in the selected byte on the next cycle
         assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == SEL_W'(i)) |=> (alm[i] == $past(wr_data)));

         // R3: without a write to this byte its value holds
         assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_sel == SEL_W'(i)) |=> $stable(alm[i]));
      end else begin : g_absent
         // absent date byte reads as the "unset" code
         assign alm[i] = '0;
      end
   end

endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
   import bcd_alarm_pkg::*;
#(
   parameter int        W    = BCD_BYTE_W,
   parameter cmp_kind_e KIND = CMP_CLOCK
) (
   input  logic [W-1:0] alm,
   input  logic [W-1:0] cur,
   output logic         hit
);

   localparam int LOW_W = W - 2;

   generate
      if (W != 8) begin : g_bad_width
         $error("alarm_field_cmp: BCD field must be one byte");
      end
   endgenerate

   logic wild;
   logic same;

   generate
      if (KIND == CMP_MDAY) begin : g_mday
         logic [LOW_W-1:0] alm_lo;
         logic             unused_hi;
         assign alm_lo    = alm[LOW_W-1:0];
         assign unused_hi = ^{alm[W-1:LOW_W], cur[W-1:LOW_W]};
         assign wild      = (alm_lo == '0) || (&alm_lo);
         assign same      = (alm_lo == cur[LOW_W-1:0]);
      end else if (KIND == CMP_MONTH) begin : g_month
         assign wild = (alm == '0) || (&alm[W-1:LOW_W]);
         assign same = (alm == cur);
      end else begin : g_clock
         assign wild = &alm[W-1:LOW_W];
         assign same = (alm == cur);
      end
   endgenerate

   assign hit = wild | same;

endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
   import bcd_alarm_pkg::*;
#(
   parameter int W        = BCD_BYTE_W,
   parameter bit HAS_DATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic [W-1:0]         cur_sec,
   input  logic [W-1:0]         cur_min,
   input  logic [W-1:0]         cur_hour,
   input  logic [W-1:0]         cur_mday,
   input  logic [W-1:0]         cur_mon,
   input  logic                 wr_en,
   input  logic [ALM_SEL_W-1:0] wr_sel,
   input  logic [W-1:0]         wr_data,
   output logic                 alarm_pulse
);

   localparam int NF           = ALM_FIELDS;
   localparam int CLOCK_FIELDS = int'(SEL_MDAY);
   localparam int LOW_W        = W - 2;

   generate
      if (W != BCD_BYTE_W) begin : g_bad_width
         $error("bcd_alarm_match: W must equal one BCD byte");
      end
   endgenerate

   logic [NF-1:0][W-1:0] alm;
   logic [NF-1:0][W-1:0] cur;
   logic [NF-1:0]        hit;
   logic                 all_hit;
   logic                 pulse_q;

   assign cur[SEL_SEC]  = cur_sec;
   assign cur[SEL_MIN]  = cur_min;
   assign cur[SEL_HOUR] = cur_hour;
   assign cur[SEL_MDAY] = cur_mday;
   assign cur[SEL_MON]  = cur_mon;

   alarm_regfile #(
      .W        (W),
      .NF       (NF),
      .SEL_W    (ALM_SEL_W),
      .HAS_DATE (HAS_DATE)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .alm     (alm)
   );

   for (genvar i = 0; i < NF; i++) begin : g_cmp
      if (i < CLOCK_FIELDS || HAS_DATE) begin : g_live
         alarm_field_cmp #(
            .W    (W),
            .KIND (kind_of_field(i))
         ) u_cmp (
            .alm (alm[i]),
            .cur (cur[i]),
            .hit (hit[i])
         );
      end else begin : g_none
         logic unused_cur;
         assign unused_cur = ^{alm[i], cur[i]};
         assign hit[i]     = 1'b1;
      end
   end

   assign all_hit = &hit;

   always_ff @(posedge clk) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= tick & all_hit;
   end

   assign alarm_pulse = pulse_q;

   // R2: an alarm event only ever follows an update strobe
   assert_pulse_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_pulse |-> $past(tick));

   // R2: no strobe, no event next cycle
   assert_idle_no_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> !alarm_pulse);

   // R5: a non-wildcard seconds byte that differs from the time blocks the event
   assert_sec_miss_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(&alm[SEL_SEC][W-1:LOW_W]) && alm[SEL_SEC] != cur_sec) |=> !alarm_pulse);

   // R6: a set day byte whose low bits differ from the day blocks the event
   assert_mday_miss_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && HAS_DATE && alm[SEL_MDAY][LOW_W-1:0] != '0 && !(&alm[SEL_MDAY][LOW_W-1:0])
       && alm[SEL_MDAY][LOW_W-1:0] != cur_mday[LOW_W-1:0]) |=> !alarm_pulse);

endmodule

// File: tb/bcd_alarm_match_tb.sv
`timescale 1ns/1ps
module bcd_alarm_match_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
   logic [7:0] cur_mday = 8'h01, cur_mon = 8'h01;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic       pulse_d, pulse_n;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   bcd_alarm_match #(.W(8), .HAS_DATE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
      .cur_mday(cur_mday), .cur_mon(cur_mon),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .alarm_pulse(pulse_d));

   bcd_alarm_match #(.W(8), .HAS_DATE(1'b0)) u_dut_nd (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
      .cur_mday(cur_mday), .cur_mon(cur_mon),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .alarm_pulse(pulse_n));

   // reference model
   int m_full[5];
   int m_nd[5];
   bit exp_d = 1'b0, exp_n = 1'b0;

   function automatic bit model_hit(input int a[5], input bit date);
      int cv[5];
      bit ok;
      cv[0] = cur_sec; cv[1] = cur_min; cv[2] = cur_hour;
      cv[3] = cur_mday; cv[4] = cur_mon;
      ok = 1'b1;
      for (int k = 0; k < 3; k++)
         if (!((a[k] / 64) == 3 || a[k] == cv[k])) ok = 1'b0;
      if (date) begin
         if (!((a[3] % 64) == 0 || (a[3] % 64) == 63 || (a[3] % 64) == (cv[3] % 64))) ok = 1'b0;
         if (!(a[4] == 0 || (a[4] / 64) == 3 || a[4] == cv[4])) ok = 1'b0;
      end
      return ok;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 5; k++) begin m_full[k] = 0; m_nd[k] = 0; end
         exp_d = 1'b0;
         exp_n = 1'b0;
      end else begin
         exp_d = tick && model_hit(m_full, 1'b1);
         exp_n = tick && model_hit(m_nd, 1'b0);
         if (wr_en && wr_sel < 5) m_full[wr_sel] = wr_data;
         if (wr_en && wr_sel < 3) m_nd[wr_sel] = wr_data;
      end
   end

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(cur_req, "full pulse", pulse_d, exp_d);
         check((cur_req == "R1") ? "R1" : "R9", "no-date pulse", pulse_n, exp_n);
      end
   end

   task automatic idle();
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                           input logic [7:0] d, input logic [7:0] mo);
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
      cur_hour = h; cur_min = m; cur_sec = s; cur_mday = d; cur_mon = mo;
   endtask

   task automatic do_tick();
      @(negedge clk);
      tick = 1'b1; wr_en = 1'b0;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic wr(input logic [2:0] sel, input logic [7:0] data);
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic probe(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                        input logic [7:0] d, input logic [7:0] mo);
      set_time(h, m, s, d, mo);
      do_tick();
      idle();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "pulse during reset", pulse_d, 1'b0);
      check("R1", "no-date pulse during reset", pulse_n, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1";
      probe(8'h00, 8'h00, 8'h00, 8'h15, 8'h06);   // default alarm is midnight
      probe(8'h00, 8'h00, 8'h01, 8'h15, 8'h06);

      cur_req = "R5";
      wr(3'd2, 8'h12); wr(3'd1, 8'h34); wr(3'd0, 8'h56);
      probe(8'h12, 8'h34, 8'h56, 8'h15, 8'h06);
      probe(8'h12, 8'h34, 8'h57, 8'h15, 8'h06);
      probe(8'h13, 8'h34, 8'h56, 8'h15, 8'h06);
      probe(8'h12, 8'h35, 8'h56, 8'h15, 8'h06);
      wr(3'd0, 8'h80);                              // top bits 10: not a wildcard
      probe(8'h12, 8'h34, 8'h00, 8'h15, 8'h06);
      probe(8'h12, 8'h34, 8'h59, 8'h15, 8'h06);

      cur_req = "R4";
      wr(3'd0, 8'hFF);
      probe(8'h12, 8'h34, 8'h00, 8'h15, 8'h06);
      probe(8'h12, 8'h34, 8'h42, 8'h15, 8'h06);
      wr(3'd0, 8'hC5);
      probe(8'h12, 8'h34, 8'h17, 8'h15, 8'h06);
      wr(3'd1, 8'hFF); wr(3'd2, 8'hD0);
      probe(8'h07, 8'h21, 8'h33, 8'h15, 8'h06);

      cur_req = "R10";
      set_time(8'h07, 8'h21, 8'h33, 8'h15, 8'h06);
      @(negedge clk); tick = 1'b1;
      @(negedge clk); cur_sec = 8'h34;
      @(negedge clk); cur_sec = 8'h35;
      @(negedge clk); tick = 1'b0;
      idle();

      cur_req = "R6";
      wr(3'd3, 8'hD5);
      probe(8'h07, 8'h21, 8'h33, 8'h15, 8'h06);
      probe(8'h07, 8'h21, 8'h33, 8'h16, 8'h06);
      probe(8'h07, 8'h21, 8'h33, 8'h55, 8'h06);

      cur_req = "R7";
      wr(3'd3, 8'h40);
      probe(8'h07, 8'h21, 8'h33, 8'h28, 8'h06);
      wr(3'd3, 8'hFF);
      probe(8'h07, 8'h21, 8'h33, 8'h31, 8'h06);
      wr(3'd3, 8'h00);
      probe(8'h07, 8'h21, 8'h33, 8'h02, 8'h06);

      cur_req = "R8";
      wr(3'd4, 8'h06);
      probe(8'h07, 8'h21, 8'h33, 8'h02, 8'h06);
      probe(8'h07, 8'h21, 8'h33, 8'h02, 8'h07);
      wr(3'd4, 8'hC3);
      probe(8'h07, 8'h21, 8'h33, 8'h02, 8'h11);
      wr(3'd4, 8'h00);
      probe(8'h07, 8'h21, 8'h33, 8'h02, 8'h12);

      cur_req = "R9";
      wr(3'd3, 8'h09); wr(3'd4, 8'h03);
      probe(8'h07, 8'h21, 8'h33, 8'h02, 8'h12);
      probe(8'h07, 8'h21, 8'h33, 8'h09, 8'h03);

      cur_req = "R3";
      wr(3'd3, 8'h00); wr(3'd4, 8'h00);
      wr(3'd0, 8'h56); wr(3'd1, 8'h34); wr(3'd2, 8'h12);
      wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
      probe(8'h12, 8'h34, 8'h11, 8'h02, 8'h12);     // unused codes left sec exact
      set_time(8'h12, 8'h34, 8'h56, 8'h02, 8'h12);
      @(negedge clk);                                 // write together with a strobe
      tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h10;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
      idle();
      probe(8'h12, 8'h34, 8'h56, 8'h02, 8'h12);
      probe(8'h12, 8'h34, 8'h10, 8'h02, 8'h12);

      repeat (2) idle();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule